// File: doc/BRIEF.md
# Half-Bridge Gate Interlock

This block sits between the control logic and the two gate drivers of one half-bridge leg. It accepts an active-low command for the upper (high-side) switch and an active-high command for the lower (low-side) switch. It resolves these into two gate-enable outputs that are never on together. The two commands are synchronised first. Any request for both switches at once is turned into "both off".

The high-side path models an isolated link. An edge of the resolved high-side request launches a fixed-width pulse on one of two wires: the set wire on a turn-on and the reset wire on a turn-off. On the far side, a noise filter passes a pulse only when exactly one wire has been active for a minimum number of consecutive cycles. A passed pulse sets or clears a latch that drives the high-side enable. The low-side request goes through a shift register whose depth equals that link latency, so both outputs move on the same clock edge.

Two undervoltage flags, one per supply domain, arrive as clean digital levels in the clock domain. A low-side undervoltage turns off both outputs. A high-side undervoltage turns off only the upper output. Either flag empties the high-side latch, so the upper switch comes back only on a new turn-on edge after the flag has cleared. One input forces activity onto the link wires to model coupled disturbance; it is tied to zero in use.

Top module: `hb_gate_interlock`

## Requirements
- R1: In steady state `hs_gate` is 1 exactly when `hs_cmd_n`=0 and `ls_cmd`=0, and `ls_gate` is 1 exactly when `ls_cmd`=1 and `hs_cmd_n`=1.
- R2: The combination `hs_cmd_n`=0 with `ls_cmd`=1 is resolved to both outputs off, and `hs_gate` and `ls_gate` are never 1 in the same cycle for any input sequence.
- R3: While `ls_uv`=1 both outputs are 0 in the same cycle. When `ls_uv` clears, `ls_gate` follows its command again at once. The high-side latch is emptied, so `hs_gate` stays 0 until a new turn-on edge.
- R4: While `hs_uv`=1, `hs_gate` is 0 and `ls_gate` is unaffected. A high-side command edge made during `hs_uv` has no effect. After the flag clears, `hs_gate` stays 0 until a new turn-on edge.
- R5: Each rising edge of the resolved high-side request sends a PULSE_W-cycle pulse on the set wire, and each falling edge sends one on the reset wire. That pulse alone turns the high side on or off.
- R6: `link_disturb` bit 0 drives the set wire and bit 1 drives the reset wire. Cycles with both wires active are ignored, and they break a run in progress. A wire acts only after it has been the only active wire for MIN_W consecutive cycles.
- R7: A command change driven before clock edge 1 shows on the affected outputs at edge MIN_W+3 and not earlier, on both the high-side and low-side paths.
- R8: During a hand-over in either direction, one output falls on the same edge as the other rises. Whenever the low side is on or about to turn on, a set pulse is refused.
- R9: Reset is synchronous and active-low. While `rst_n`=0 both outputs are 0 on the next edge, whatever the commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_cmd_n | input | 1 | High-side command, active-low, asynchronous |
| ls_cmd | input | 1 | Low-side command, active-high, asynchronous |
| ls_uv | input | 1 | Low-side supply undervoltage, clock-domain level |
| hs_uv | input | 1 | High-side supply undervoltage, clock-domain level |
| link_disturb | input | 2 | Forced activity on the link: bit 0 set wire, bit 1 reset wire |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The bench goes through every ordered pair of the four command combinations and checks that the old outputs hold one edge before the expected latency and the new ones appear on it. A low-side delay one stage off from the link would show a cycle of overlap or a missing edge there. Disturbance tests drive both wires together, single-wire runs one cycle short of the minimum, and runs broken by a common-mode cycle. A filter that counted total active cycles, or that let simultaneous activity through, would turn the high side on or off. The undervoltage tests give a command edge during the flag and check the outputs after it clears. They catch a latch that survives the flag and an edge that stays queued until the flag drops.

// File: rtl/hb_pkg.sv
// Package hb_pkg
// Shared types for the half-bridge gate interlock.
// Assumes: nothing; pure type definitions.
package hb_pkg;

    // State of the two-wire pulse link as driven by the transmitter.
    typedef enum logic [1:0] {
        LINK_IDLE = 2'b00,
        LINK_SET  = 2'b01,
        LINK_RST  = 2'b10
    } link_e;

endpackage

// File: rtl/hb_sync2.sv
// Module hb_sync2
// Two-flop synchroniser for a vector of independent asynchronous levels.
// Assumes: each bit is a slow level; the bits are not a coherent bus.
module hb_sync2 #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages to settle metastable samples.
    always_ff @(posedge clk) begin : sync_regs
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/hb_pulse_tx.sv
// Module hb_pulse_tx
// Converts edges of the high-side request into PULSE_W-cycle pulses on a
// set wire (turn-on) or a reset wire (turn-off).
// Assumes: hs_req is synchronous; hold (low-side undervoltage) silences the
// link but the edge detector keeps tracking, so edges made during hold are
// consumed and never sent later.
module hb_pulse_tx
    import hb_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic hold,
    output logic set_ch,
    output logic rst_ch
);

    localparam int CW = $clog2(PULSE_W + 1);

    logic          req_d;
    logic          on_edge;
    logic          off_edge;
    link_e         cur;
    logic [CW-1:0] left;

    // Previous request value for edge detection.
    always_ff @(posedge clk) begin : req_hist
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= hs_req;
    end

    // Edge classification of the request.
    always_comb begin : edge_detect
        on_edge  = hs_req && !req_d;
        off_edge = !hs_req && req_d;
    end

    // Drives the link for PULSE_W cycles after each edge; a new edge restarts it.
    always_ff @(posedge clk) begin : tx_seq
        if (!rst_n || hold) begin
            cur  <= LINK_IDLE;
            left <= '0;
        end else if (on_edge) begin
            cur  <= LINK_SET;
            left <= CW'(PULSE_W - 1);
        end else if (off_edge) begin
            cur  <= LINK_RST;
            left <= CW'(PULSE_W - 1);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end else begin
            cur  <= LINK_IDLE;
        end
    end

    // Wire outputs decoded from the link state.
    always_comb begin : wire_decode
        set_ch = (cur == LINK_SET);
        rst_ch = (cur == LINK_RST);
    end

    // R5: a turn-on edge starts a set pulse on the next cycle.
    p_on_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (on_edge && !hold) |=> (set_ch && !rst_ch));

    // R5: a turn-off edge starts a reset pulse on the next cycle.
    p_off_edge_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (off_edge && !hold) |=> (rst_ch && !set_ch));

endmodule

// File: rtl/hb_pulse_rx.sv
// Module hb_pulse_rx
// Noise filter and high-side latch. A wire counts as a command only after it
// has been the sole active wire for MIN_W consecutive cycles; cycles with
// both wires active reset both runs. The latch is emptied by undervoltage and
// by the low side being about to conduct, which also blocks a set.
// Assumes: MIN_W >= 1 and MIN_W <= PULSE_W of the transmitter.
module hb_pulse_rx #(
    parameter int MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic rst_in,
    input  logic clear,
    input  logic ls_next,
    output logic hs_q
);

    localparam int RW = $clog2(MIN_W + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(MIN_W);
    localparam logic [RW-1:0] RUN_HIT = RW'(MIN_W - 1);

    logic          set_only;
    logic          rst_only;
    logic          set_acc;
    logic          rst_acc;
    logic [RW-1:0] run_s;
    logic [RW-1:0] run_r;

    // Qualify each wire as the only active one and detect the accepting cycle.
    always_comb begin : qualify
        set_only = set_in && !rst_in;
        rst_only = rst_in && !set_in;
        set_acc  = set_only && (run_s == RUN_HIT);
        rst_acc  = rst_only && (run_r == RUN_HIT);
    end

    // Saturating run counters of consecutive sole-active cycles per wire.
    always_ff @(posedge clk) begin : run_count
        if (!rst_n || clear) begin
            run_s <= '0;
            run_r <= '0;
        end else begin
            run_s <= !set_only ? '0 : (run_s == RUN_MAX ? run_s : run_s + 1'b1);
            run_r <= !rst_only ? '0 : (run_r == RUN_MAX ? run_r : run_r + 1'b1);
        end
    end

    // High-side latch: reset wins over set, low side lockout wins over both.
    always_ff @(posedge clk) begin : hs_latch
        if (!rst_n || clear || ls_next) hs_q <= 1'b0;
        else if (rst_acc)               hs_q <= 1'b0;
        else if (set_acc)               hs_q <= 1'b1;
    end

    // R6: a common-mode cycle never changes the latch on its own.
    p_common_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_in && rst_in && !clear && !ls_next) |=> (hs_q == $past(hs_q)));

    // R6: the latch only turns on after the set wire was the sole active wire.
    p_set_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> $past(set_in && !rst_in));

    // R3 / R4: any undervoltage empties the latch.
    p_uv_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hs_q);

endmodule

// File: rtl/hb_delay_line.sv
// Module hb_delay_line
// Shift register that delays the low-side request by DEPTH cycles, and
// exposes the value the tail will take on the next edge.
// Assumes: DEPTH >= 1.
module hb_delay_line #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic tail_next,
    output logic tail
);

    logic [DEPTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_one
            // Single stage delay.
            always_ff @(posedge clk) begin : shift_one
                if (!rst_n) stg <= '0;
                else        stg <= d;
            end
            assign tail_next = d;
        end else begin : g_many
            // Multi stage shift toward the tail.
            always_ff @(posedge clk) begin : shift_many
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-2:0], d};
            end
            assign tail_next = stg[DEPTH-2];
        end
    endgenerate

    assign tail = stg[DEPTH-1];

endmodule

// File: rtl/hb_gate_interlock.sv
// Module hb_gate_interlock
// Half-bridge gate interlock: synchronises the two commands, resolves the
// forbidden combination to both off, sends high-side edges over a two-wire
// pulse link into a filtered latch, delays the low side by the link latency,
// and gates both outputs with the undervoltage flags.
// Assumes: ls_uv and hs_uv are glitch-free levels already in the clk domain;
// link_disturb is zero in use and only models coupled noise; MIN_W <= PULSE_W.
module hb_gate_interlock #(
    parameter int PULSE_W = 4,
    parameter int MIN_W   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_cmd_n,
    input  logic       ls_cmd,
    input  logic       ls_uv,
    input  logic       hs_uv,
    input  logic [1:0] link_disturb,
    output logic       hs_gate,
    output logic       ls_gate
);

    // Transmit register plus MIN_W filter cycles.
    localparam int LS_DEPTH = MIN_W + 1;

    logic [1:0] cmd_s;
    logic       hs_req;
    logic       ls_req;
    logic       tx_set;
    logic       tx_rst;
    logic       link_set;
    logic       link_rst;
    logic       ls_next;
    logic       ls_tail;
    logic       hs_q;

    hb_sync2 #(
        .W       (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hs_cmd_n, ls_cmd}),
        .q     (cmd_s)
    );

    // Resolve command polarity; the forbidden combination requests nothing.
    always_comb begin : arbitrate
        hs_req = !cmd_s[1] && !cmd_s[0];
        ls_req =  cmd_s[1] &&  cmd_s[0];
    end

    hb_pulse_tx #(
        .PULSE_W (PULSE_W)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_req (hs_req),
        .hold   (ls_uv),
        .set_ch (tx_set),
        .rst_ch (tx_rst)
    );

    // Link wires as seen by the receiver, including coupled disturbance.
    always_comb begin : link_wires
        link_set = tx_set || link_disturb[0];
        link_rst = tx_rst || link_disturb[1];
    end

    hb_pulse_rx #(
        .MIN_W (MIN_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_in  (link_set),
        .rst_in  (link_rst),
        .clear   (ls_uv || hs_uv),
        .ls_next (ls_next),
        .hs_q    (hs_q)
    );

    hb_delay_line #(
        .DEPTH (LS_DEPTH)
    ) u_ls_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .d         (ls_req),
        .tail_next (ls_next),
        .tail      (ls_tail)
    );

    // Output gating by the undervoltage flags.
    always_comb begin : out_gate
        hs_gate = hs_q && !hs_uv && !ls_uv;
        ls_gate = ls_tail && !ls_uv;
    end

    // R2: the two gate enables are never on together.
    p_gates_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R8: latch and delayed low side never overlap, including hand-over edges.
    p_latch_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_q && ls_tail));

endmodule

// File: tb/hb_gate_interlock_tb_top.sv
// Bench for hb_gate_interlock: sweeps all command transitions, undervoltage
// cases and link disturbance patterns with arithmetic expectations.
module hb_gate_interlock_tb_top;

    localparam int PW  = 4;
    localparam int MW  = 3;
    localparam int LAT = MW + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_cmd_n = 1'b1;
    logic       ls_cmd = 1'b0;
    logic       ls_uv = 1'b0;
    logic       hs_uv = 1'b0;
    logic [1:0] link_disturb = 2'b00;
    logic       hs_gate;
    logic       ls_gate;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hb_gate_interlock #(
        .PULSE_W (PW),
        .MIN_W   (MW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_cmd_n     (hs_cmd_n),
        .ls_cmd       (ls_cmd),
        .ls_uv        (ls_uv),
        .hs_uv        (hs_uv),
        .link_disturb (link_disturb),
        .hs_gate      (hs_gate),
        .ls_gate      (ls_gate)
    );

    function automatic logic exp_hs(logic hn, logic ls);
        return !hn && !ls;
    endfunction

    function automatic logic exp_ls(logic hn, logic ls);
        return hn && ls;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle(logic hn, logic ls);
        hs_cmd_n = hn;
        ls_cmd   = ls;
        wait_n(LAT + 2);
    endtask

    task automatic pulse_link(logic [1:0] v, int n);
        link_disturb = v;
        wait_n(n);
        link_disturb = 2'b00;
        wait_n(1);
    endtask

    // R2: overlap monitor sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && hs_gate && ls_gate) overlaps++;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: commands asking for the high side during reset are held off.
        hs_cmd_n = 1'b0;
        wait_n(3);
        chk("R9", "hs_gate in reset", hs_gate, 0);
        chk("R9", "ls_gate in reset", ls_gate, 0);
        hs_cmd_n = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        chk("R9", "hs_gate after reset", hs_gate, 0);
        chk("R9", "ls_gate after reset", ls_gate, 0);

        // R1 R7 R8: every ordered pair of command combinations.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic ah = a[1];
                logic al = a[0];
                logic bh = b[1];
                logic bl = b[0];
                settle(ah, al);
                hs_cmd_n = bh;
                ls_cmd   = bl;
                for (int k = 1; k <= LAT + 1; k++) begin
                    @(negedge clk);
                    if (k == LAT - 1) begin
                        chk("R7", $sformatf("hs held %0d->%0d", a, b), hs_gate, exp_hs(ah, al));
                        chk("R7", $sformatf("ls held %0d->%0d", a, b), ls_gate, exp_ls(ah, al));
                    end
                    if (k == LAT) begin
                        chk("R1", $sformatf("hs new %0d->%0d", a, b), hs_gate, exp_hs(bh, bl));
                        chk("R1", $sformatf("ls new %0d->%0d", a, b), ls_gate, exp_ls(bh, bl));
                    end
                end
            end
        end

        // R2: conflicting combination resolves to both off.
        settle(1'b0, 1'b1);
        chk("R2", "hs_gate conflict", hs_gate, 0);
        chk("R2", "ls_gate conflict", ls_gate, 0);

        // R3: low-side undervoltage with low side on.
        settle(1'b1, 1'b1);
        ls_uv = 1'b1;
        wait_n(1);
        chk("R3", "ls_gate under ls_uv", ls_gate, 0);
        ls_uv = 1'b0;
        wait_n(1);
        chk("R3", "ls_gate after ls_uv", ls_gate, 1);

        // R3: low-side undervoltage with high side on; needs a fresh edge.
        settle(1'b0, 1'b0);
        chk("R5", "hs on before ls_uv", hs_gate, 1);
        ls_uv = 1'b1;
        wait_n(1);
        chk("R3", "hs_gate under ls_uv", hs_gate, 0);
        wait_n(3);
        ls_uv = 1'b0;
        wait_n(LAT + 2);
        chk("R3", "hs_gate stays off after ls_uv", hs_gate, 0);
        settle(1'b1, 1'b0);
        settle(1'b0, 1'b0);
        chk("R5", "hs on after fresh edge", hs_gate, 1);

        // R3: low-side command during ls_uv only gated.
        settle(1'b1, 1'b0);
        ls_uv = 1'b1;
        settle(1'b1, 1'b1);
        chk("R3", "ls_gate commanded under ls_uv", ls_gate, 0);
        ls_uv = 1'b0;
        wait_n(1);
        chk("R3", "ls_gate resumes", ls_gate, 1);

        // R4: high-side undervoltage with high side on.
        settle(1'b0, 1'b0);
        hs_uv = 1'b1;
        wait_n(1);
        chk("R4", "hs_gate under hs_uv", hs_gate, 0);
        hs_uv = 1'b0;
        wait_n(LAT + 2);
        chk("R4", "hs_gate stays off after hs_uv", hs_gate, 0);

        // R4: high-side undervoltage leaves the low side alone.
        settle(1'b1, 1'b1);
        hs_uv = 1'b1;
        wait_n(1);
        chk("R4", "ls_gate under hs_uv", ls_gate, 1);
        hs_uv = 1'b0;

        // R4: a turn-on edge during hs_uv has no effect later.
        settle(1'b1, 1'b0);
        hs_uv = 1'b1;
        hs_cmd_n = 1'b0;
        wait_n(12);
        chk("R4", "hs_gate edge during hs_uv", hs_gate, 0);
        hs_uv = 1'b0;
        wait_n(12);
        chk("R4", "hs_gate after hs_uv clears", hs_gate, 0);
        settle(1'b1, 1'b0);
        settle(1'b0, 1'b0);
        chk("R4", "hs_gate after fresh edge", hs_gate, 1);

        // R6: link disturbance, starting from idle with both off.
        settle(1'b1, 1'b0);
        pulse_link(2'b11, 10);
        chk("R6", "common-mode does not set", hs_gate, 0);
        pulse_link(2'b01, MW - 1);
        chk("R6", "short set rejected", hs_gate, 0);
        link_disturb = 2'b01;
        wait_n(MW - 1);
        link_disturb = 2'b11;
        wait_n(1);
        link_disturb = 2'b01;
        wait_n(MW - 1);
        link_disturb = 2'b00;
        wait_n(1);
        chk("R6", "broken set run rejected", hs_gate, 0);
        pulse_link(2'b01, MW);
        chk("R6", "full set accepted", hs_gate, 1);
        pulse_link(2'b11, 10);
        chk("R6", "common-mode does not reset", hs_gate, 1);
        pulse_link(2'b10, MW - 1);
        chk("R6", "short reset rejected", hs_gate, 1);
        pulse_link(2'b10, MW);
        chk("R6", "full reset accepted", hs_gate, 0);

        // R8: set pulses are refused while the low side conducts.
        settle(1'b1, 1'b1);
        pulse_link(2'b01, MW + 2);
        chk("R8", "set refused with low side on (hs)", hs_gate, 0);
        chk("R8", "set refused with low side on (ls)", ls_gate, 1);

        // R9: reset in mid-run turns the high side off.
        settle(1'b0, 1'b0);
        rst_n = 1'b0;
        wait_n(1);
        chk("R9", "hs_gate after mid reset", hs_gate, 0);
        hs_cmd_n = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(2);

        chk("R2", "overlap cycles", overlaps, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule